// File: doc/BRIEF.md
# Status Register Write Unit

This block keeps the current status word of a processor core and one saved status word for each privileged bank. A move-to-status instruction hands it a 32-bit value, a four-bit lane mask and a select between the current word and the saved word of the active bank. Only the enabled byte lanes are written. While the core is in user mode, a write to the current word is limited to the top byte, which holds the condition flags.

Alongside the register file, the block works out the N, Z, C and V condition flags from an ALU result, the operand sign bits and an add/subtract select. These flags are available on every cycle. They are loaded into the current word when the flag load is asserted and no status write to the current word is pending in that cycle. When a write changes the mode field, the block raises a one-cycle strobe that carries the old and new mode codes. The register bank uses this strobe to swap its banked registers.

Instruction decode and the ALU datapath sit outside this block.

Top module: `psr_write_unit`

## Requirements
- R1: Mask bit 0 enables bits 7:0, bit 1 enables bits 15:8, bit 2 enables bits 23:16 and bit 3 enables bits 31:24. A write updates only the enabled lanes, and the change shows on the outputs from the cycle after the write.
- R2: In user mode (mode field 5'h10 or 5'h00), a write to the current word changes bits 31:24 only. Bits 23:0 keep their values.
- R3: User mode and system mode (5'h1F), and any mode code not listed in R4, have no saved word. In these modes a saved-word write is dropped, and the saved-word output shows the current word.
- R4: Modes 5'h11/5'h01, 5'h12/5'h02, 5'h13/5'h03, 5'h17 and 5'h1B each own a separate saved word. A saved-word write goes only to the word of the active mode, and the saved-word output shows that word.
- R5: The current word's mode field is bits 4:0. When a write changes it, the mode-switch strobe is high for exactly one cycle, in the same cycle as the new word, with the old and new mode codes. A write that leaves the mode unchanged raises no strobe.
- R6: For an add, C is set when both operand signs are 1, or when either operand sign is 1 and result bit 31 is 0.
- R7: For a subtract, C (no borrow) is set when a is negative and b is not, or a is negative and the result is not, or b and the result are both non-negative.
- R8: For an add, V is set when the operand signs match and the result sign differs from them. For a subtract, V is set when the operand signs differ and the result sign differs from a.
- R9: N equals result bit 31. Z is set exactly when the result is zero.
- R10: When the flag load is asserted, the current word's bits 31:28 take {N,Z,C,V} on the next cycle. All other bits are unchanged.
- R11: In a cycle with a write to the current word, the flag load is ignored, whatever the lane mask.
- R12: After reset, the current word is 32'h000000D3 (supervisor mode, I and F set), every saved word is zero and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Status write request |
| wrSpsr | input | 1 | Write target: 1 = saved word of the active bank, 0 = current word |
| fieldMask | input | 4 | Byte lane enables |
| wrData | input | 32 | Write value |
| flagEn | input | 1 | Load the ALU flags into the current word |
| aluSub | input | 1 | 1 = subtract, 0 = add |
| opASign | input | 1 | Sign bit of operand a |
| opBSign | input | 1 | Sign bit of operand b |
| aluRes | input | 32 | ALU result |
| cpsr | output | 32 | Current status word |
| spsr | output | 32 | Saved word of the active bank, or the current word when the bank has none |
| flagN | output | 1 | Negative flag from the result |
| flagZ | output | 1 | Zero flag from the result |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| modeSwitch | output | 1 | One-cycle strobe on a mode change |
| oldMode | output | 5 | Mode code before the latest switch |
| newMode | output | 5 | Mode code after the latest switch |

## Verification
A wrong lane enable or a broken user-mode limit shows on the current-word output one cycle after the write. A wrong bank-to-slot mapping stays hidden until the core returns to a bank, and it then shows as the wrong saved word on the first cycle in that mode. That is why the tests leave a bank, write another bank, and then come back. A missing or extra mode-switch strobe shows in the same cycle as the new mode field. A wrong flag term shows at once on the flag outputs, and it shows in the current word one cycle after a flag load.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W    = 32;
  localparam int LANE_W   = 8;
  localparam int LANES    = PSR_W / LANE_W;
  localparam int MODE_W   = 5;
  localparam int NUM_SPSR = 5;
  localparam int SLOT_W   = $clog2(NUM_SPSR);
  localparam int FLAG_LSB = PSR_W - 4;

  localparam logic [PSR_W-1:0] PSR_RESET = 32'h0000_00D3;

  typedef enum logic [2:0] {
    BANK_USR, BANK_FIQ, BANK_IRQ, BANK_SVC,
    BANK_ABT, BANK_UND, BANK_SYS, BANK_NONE
  } bank_e;

  typedef struct packed {
    logic [LANES-1:0]  cpsrLaneEn;
    logic [LANES-1:0]  spsrLaneEn;
    logic [SLOT_W-1:0] spsrSlot;
    logic              hasSpsr;
    logic              flagLoad;
  } psr_strobe_t;

  function automatic bank_e modeToBank(input logic [MODE_W-1:0] m);
    case (m)
      5'h00, 5'h10: return BANK_USR;
      5'h01, 5'h11: return BANK_FIQ;
      5'h02, 5'h12: return BANK_IRQ;
      5'h03, 5'h13: return BANK_SVC;
      5'h17:        return BANK_ABT;
      5'h1B:        return BANK_UND;
      5'h1F:        return BANK_SYS;
      default:      return BANK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/psr_ctrl.sv
module psr_ctrl
  import psr_pkg::*;
(
  input  logic              wrEn,
  input  logic              wrSpsr,
  input  logic [LANES-1:0]  fieldMask,
  input  logic              flagEn,
  input  logic [MODE_W-1:0] curMode,
  output psr_strobe_t       strb
);
  localparam logic [LANES-1:0] USER_LANES = {1'b1, {(LANES-1){1'b0}}};

  bank_e curBank;
  logic  userMode;
  logic  cpsrWr;
  logic  spsrWr;

  always_comb begin
    curBank  = modeToBank(curMode);
    userMode = (curBank == BANK_USR);
    cpsrWr   = wrEn & ~wrSpsr;
    spsrWr   = wrEn & wrSpsr;

    strb.hasSpsr  = (curBank == BANK_FIQ) || (curBank == BANK_IRQ) ||
                    (curBank == BANK_SVC) || (curBank == BANK_ABT) ||
                    (curBank == BANK_UND);
    strb.spsrSlot = strb.hasSpsr ? (SLOT_W'(curBank) - SLOT_W'(1)) : '0;

    if (!cpsrWr)
      strb.cpsrLaneEn = '0;
    else if (userMode)
      strb.cpsrLaneEn = fieldMask & USER_LANES;
    else
      strb.cpsrLaneEn = fieldMask;

    strb.spsrLaneEn = (spsrWr && strb.hasSpsr) ? fieldMask : '0;
    strb.flagLoad   = flagEn & ~cpsrWr;
  end
endmodule

// File: rtl/psr_flags.sv
module psr_flags
  import psr_pkg::*;
(
  input  logic             aluSub,
  input  logic             opASign,
  input  logic             opBSign,
  input  logic [PSR_W-1:0] aluRes,
  output logic [3:0]       aluFlags
);
  logic resSign;
  logic nBit, zBit, cBit, vBit;

  always_comb begin
    resSign = aluRes[PSR_W-1];
    nBit    = resSign;
    zBit    = (aluRes == '0);
    if (aluSub) begin
      cBit = (opASign & ~opBSign) | (opASign & ~resSign) | (~opBSign & ~resSign);
      vBit = (opASign ^ opBSign) & (resSign ^ opASign);
    end else begin
      cBit = (opASign & opBSign) | ((opASign | opBSign) & ~resSign);
      vBit = ~(opASign ^ opBSign) & (resSign ^ opASign);
    end
    aluFlags = {nBit, zBit, cBit, vBit};
  end
endmodule

// File: rtl/psr_datapath.sv
module psr_datapath
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  psr_strobe_t       strb,
  input  logic [PSR_W-1:0]  wrData,
  input  logic [3:0]        aluFlags,
  output logic [PSR_W-1:0]  cpsr,
  output logic [PSR_W-1:0]  spsrSel,
  output logic              modeSwitch,
  output logic [MODE_W-1:0] oldMode,
  output logic [MODE_W-1:0] newMode
);
  logic [PSR_W-1:0] cpsrQ;
  logic [PSR_W-1:0] laneMerged;
  logic [PSR_W-1:0] cpsrNext;
  logic [PSR_W-1:0] spsrBank [NUM_SPSR];

  for (genvar l = 0; l < LANES; l++) begin : g_cpsrLane
    assign laneMerged[l*LANE_W +: LANE_W] =
      strb.cpsrLaneEn[l] ? wrData[l*LANE_W +: LANE_W] : cpsrQ[l*LANE_W +: LANE_W];
  end

  always_comb begin
    cpsrNext = laneMerged;
    if (strb.flagLoad)
      cpsrNext[PSR_W-1:FLAG_LSB] = aluFlags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsrQ      <= PSR_RESET;
      modeSwitch <= 1'b0;
      oldMode    <= PSR_RESET[MODE_W-1:0];
      newMode    <= PSR_RESET[MODE_W-1:0];
    end else begin
      cpsrQ      <= cpsrNext;
      modeSwitch <= (cpsrNext[MODE_W-1:0] != cpsrQ[MODE_W-1:0]);
      if (cpsrNext[MODE_W-1:0] != cpsrQ[MODE_W-1:0]) begin
        oldMode <= cpsrQ[MODE_W-1:0];
        newMode <= cpsrNext[MODE_W-1:0];
      end
    end
  end

  for (genvar s = 0; s < NUM_SPSR; s++) begin : g_spsrSlot
    logic [PSR_W-1:0] slotQ;
    logic [PSR_W-1:0] slotNext;
    logic             slotHit;

    assign slotHit = (strb.spsrSlot == SLOT_W'(s));

    for (genvar l = 0; l < LANES; l++) begin : g_spsrLane
      assign slotNext[l*LANE_W +: LANE_W] =
        (slotHit && strb.spsrLaneEn[l]) ? wrData[l*LANE_W +: LANE_W]
                                        : slotQ[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slotQ <= '0;
      else        slotQ <= slotNext;
    end

    assign spsrBank[s] = slotQ;
  end

  assign cpsr    = cpsrQ;
  assign spsrSel = strb.hasSpsr ? spsrBank[strb.spsrSlot] : cpsrQ;
endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrSpsr,
  input  logic [LANES-1:0]  fieldMask,
  input  logic [PSR_W-1:0]  wrData,
  input  logic              flagEn,
  input  logic              aluSub,
  input  logic              opASign,
  input  logic              opBSign,
  input  logic [PSR_W-1:0]  aluRes,
  output logic [PSR_W-1:0]  cpsr,
  output logic [PSR_W-1:0]  spsr,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagV,
  output logic              modeSwitch,
  output logic [MODE_W-1:0] oldMode,
  output logic [MODE_W-1:0] newMode
);
  psr_strobe_t strb;
  logic [3:0]  aluFlags;

  psr_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrSpsr    (wrSpsr),
    .fieldMask (fieldMask),
    .flagEn    (flagEn),
    .curMode   (cpsr[MODE_W-1:0]),
    .strb      (strb)
  );

  psr_flags u_flags (
    .aluSub   (aluSub),
    .opASign  (opASign),
    .opBSign  (opBSign),
    .aluRes   (aluRes),
    .aluFlags (aluFlags)
  );

  psr_datapath u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .wrData     (wrData),
    .aluFlags   (aluFlags),
    .cpsr       (cpsr),
    .spsrSel    (spsr),
    .modeSwitch (modeSwitch),
    .oldMode    (oldMode),
    .newMode    (newMode)
  );

  assign {flagN, flagZ, flagC, flagV} = aluFlags;
endmodule

// File: rtl/psr_write_unit_chk.sv
module psr_write_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic        wrSpsr,
  input logic [3:0]  fieldMask,
  input logic [31:0] wrData,
  input logic        flagEn,
  input logic        aluSub,
  input logic        opASign,
  input logic        opBSign,
  input logic [31:0] cpsr,
  input logic [31:0] spsr,
  input logic        flagN,
  input logic        flagZ,
  input logic        flagC,
  input logic        flagV,
  input logic        modeSwitch,
  input logic [4:0]  oldMode,
  input logic [4:0]  newMode
);
  logic userMode;
  logic noSaved;
  assign userMode = (cpsr[4:0] == 5'h10) || (cpsr[4:0] == 5'h00);
  assign noSaved  = userMode || (cpsr[4:0] == 5'h1F);

  AST_LANE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrSpsr && !fieldMask[0] && !flagEn) |=> (cpsr[7:0] == $past(cpsr[7:0]))); // R1

  AST_USER_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrSpsr && userMode) |=> (cpsr[23:0] == $past(cpsr[23:0]))); // R2

  AST_NO_SAVED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    noSaved |-> (spsr == cpsr)); // R3

  AST_SWITCH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr[4:0] != $past(cpsr[4:0])) |->
      (modeSwitch && newMode == cpsr[4:0] && oldMode == $past(cpsr[4:0]))); // R5

  AST_SWITCH_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    modeSwitch |-> (cpsr[4:0] != $past(cpsr[4:0]))); // R5

  AST_ADD_CARRY_BOTH_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (!aluSub && opASign && opBSign) |-> flagC); // R6

  AST_SUB_NO_OVF_SAME_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (aluSub && (opASign == opBSign)) |-> !flagV); // R8

  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    flagZ |-> !flagN); // R9

  AST_WRITE_BEATS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrSpsr && flagEn && !userMode) |=>
      (cpsr[31:24] == ($past(fieldMask[3]) ? $past(wrData[31:24]) : $past(cpsr[31:24])))); // R11
endmodule

bind psr_write_unit psr_write_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSpsr(wrSpsr), .fieldMask(fieldMask),
  .wrData(wrData), .flagEn(flagEn), .aluSub(aluSub), .opASign(opASign),
  .opBSign(opBSign), .cpsr(cpsr), .spsr(spsr), .flagN(flagN), .flagZ(flagZ),
  .flagC(flagC), .flagV(flagV), .modeSwitch(modeSwitch), .oldMode(oldMode),
  .newMode(newMode)
);

// File: tb/tb_psr_write_unit.sv
`timescale 1ns/1ps
module tb_psr_write_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSpsr = 1'b0;
  logic [3:0]  fieldMask = '0;
  logic [31:0] wrData = '0;
  logic        flagEn = 1'b0;
  logic        aluSub = 1'b0;
  logic        opASign = 1'b0;
  logic        opBSign = 1'b0;
  logic [31:0] aluRes = '0;
  logic [31:0] cpsr, spsr;
  logic        flagN, flagZ, flagC, flagV, modeSwitch;
  logic [4:0]  oldMode, newMode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  psr_write_unit dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSpsr(wrSpsr), .fieldMask(fieldMask),
    .wrData(wrData), .flagEn(flagEn), .aluSub(aluSub), .opASign(opASign),
    .opBSign(opBSign), .aluRes(aluRes), .cpsr(cpsr), .spsr(spsr), .flagN(flagN),
    .flagZ(flagZ), .flagC(flagC), .flagV(flagV), .modeSwitch(modeSwitch),
    .oldMode(oldMode), .newMode(newMode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic applyWrite(input logic sel, input logic [3:0] m, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSpsr = sel; fieldMask = m; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrSpsr = 1'b0; fieldMask = '0; wrData = '0;
  endtask

  task automatic setAlu(input logic sub, input logic [31:0] a, input logic [31:0] b);
    aluSub = sub; opASign = a[31]; opBSign = b[31];
    aluRes = sub ? (a - b) : (a + b);
  endtask

  task automatic testReset();
    doReset();
    chk("R12 cpsr", cpsr, 32'h0000_00D3);
    chk("R12 spsr", spsr, 32'h0);
    chk("R12 strobe", {31'b0, modeSwitch}, 32'h0);
  endtask

  task automatic testLanes();
    applyWrite(1'b0, 4'b0100, 32'hAABB_CCDD);
    chk("R1 lane2", cpsr, 32'h00BB_00D3);
    chk("R5 no strobe same mode", {31'b0, modeSwitch}, 32'h0);
    applyWrite(1'b0, 4'b0010, 32'h1122_3344);
    chk("R1 lane1", cpsr, 32'h00BB_33D3);
    applyWrite(1'b0, 4'b0000, 32'hFFFF_FFFF);
    chk("R1 empty mask", cpsr, 32'h00BB_33D3);
  endtask

  task automatic testBanks();
    applyWrite(1'b1, 4'b1111, 32'h1234_5678);
    chk("R4 svc saved", spsr, 32'h1234_5678);
    applyWrite(1'b0, 4'b0001, 32'h0000_0092);
    chk("R5 cpsr irq", cpsr, 32'h00BB_3392);
    chk("R5 strobe", {31'b0, modeSwitch}, 32'h1);
    chk("R5 oldMode", {27'b0, oldMode}, 32'h13);
    chk("R5 newMode", {27'b0, newMode}, 32'h12);
    chk("R4 irq saved empty", spsr, 32'h0);
    @(negedge clk);
    chk("R5 strobe one cycle", {31'b0, modeSwitch}, 32'h0);
    applyWrite(1'b1, 4'b1001, 32'hCAFE_F00D);
    chk("R4 irq masked saved", spsr, 32'hCA00_000D);
    applyWrite(1'b0, 4'b0001, 32'h0000_0093);
    chk("R4 svc saved kept", spsr, 32'h1234_5678);
    applyWrite(1'b0, 4'b0001, 32'h0000_0092);
    chk("R4 irq saved kept", spsr, 32'hCA00_000D);
    applyWrite(1'b0, 4'b0001, 32'h0000_0093);
  endtask

  task automatic testNoSaved();
    applyWrite(1'b0, 4'b0001, 32'h0000_009F);
    chk("R3 sys cpsr", cpsr, 32'h00BB_339F);
    chk("R3 sys read", spsr, cpsr);
    applyWrite(1'b1, 4'b1111, 32'hDEAD_BEEF);
    chk("R3 sys write dropped", spsr, 32'h00BB_339F);
    chk("R3 sys cpsr kept", cpsr, 32'h00BB_339F);
    applyWrite(1'b0, 4'b0001, 32'h0000_0093);
    chk("R3 svc untouched", spsr, 32'h1234_5678);
    applyWrite(1'b0, 4'b0001, 32'h0000_0010);
    chk("R3 user cpsr", cpsr, 32'h00BB_3310);
    chk("R3 user read", spsr, cpsr);
  endtask

  task automatic testUser();
    applyWrite(1'b0, 4'b1111, 32'hF000_001F);
    chk("R2 user flags only", cpsr, 32'hF0BB_3310);
    chk("R2 no strobe", {31'b0, modeSwitch}, 32'h0);
    applyWrite(1'b1, 4'b1111, 32'h0);
    chk("R3 user saved write dropped", spsr, 32'hF0BB_3310);
  endtask

  task automatic aluCase(input logic sub, input logic [31:0] a, input logic [31:0] b);
    logic [32:0] wide;
    logic [32:0] sx;
    logic [31:0] res;
    logic eN, eZ, eC, eV;
    @(negedge clk);
    setAlu(sub, a, b);
    res = sub ? (a - b) : (a + b);
    if (sub) begin
      eC = (a >= b);
      sx = {a[31], a} - {b[31], b};
    end else begin
      wide = {1'b0, a} + {1'b0, b};
      eC = wide[32];
      sx = {a[31], a} + {b[31], b};
    end
    eV = (sx[32] != sx[31]);
    eN = res[31];
    eZ = (res == 32'h0);
    #1;
    chk("R9 N", {31'b0, flagN}, {31'b0, eN});
    chk("R9 Z", {31'b0, flagZ}, {31'b0, eZ});
    chk(sub ? "R7 C" : "R6 C", {31'b0, flagC}, {31'b0, eC});
    chk("R8 V", {31'b0, flagV}, {31'b0, eV});
  endtask

  task automatic testAlu();
    aluCase(1'b0, 32'h7FFF_FFFF, 32'h0000_0001);
    aluCase(1'b0, 32'hFFFF_FFFF, 32'h0000_0001);
    aluCase(1'b0, 32'h8000_0000, 32'h8000_0000);
    aluCase(1'b0, 32'h0000_1234, 32'h0000_0001);
    aluCase(1'b1, 32'h0000_0005, 32'h0000_0005);
    aluCase(1'b1, 32'h0000_0000, 32'h0000_0001);
    aluCase(1'b1, 32'h8000_0000, 32'h0000_0001);
    aluCase(1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic testFlagLoad();
    doReset();
    @(negedge clk);
    setAlu(1'b0, 32'hFFFF_FFFF, 32'h0000_0001);
    flagEn = 1'b1;
    @(negedge clk);
    flagEn = 1'b0;
    chk("R10 flag load", cpsr, 32'h6000_00D3);
  endtask

  task automatic testPriority();
    @(negedge clk);
    setAlu(1'b0, 32'h7FFF_FFFF, 32'h0000_0001);
    flagEn = 1'b1; wrEn = 1'b1; wrSpsr = 1'b0; fieldMask = 4'b1000; wrData = 32'h3000_0000;
    @(negedge clk);
    wrData = 32'h0000_00D3; fieldMask = 4'b0001;
    chk("R11 write wins", cpsr, 32'h3000_00D3);
    @(negedge clk);
    wrEn = 1'b0; fieldMask = '0; wrData = '0;
    chk("R11 flags suppressed without flag lane", cpsr, 32'h3000_00D3);
    @(negedge clk);
    flagEn = 1'b0;
    chk("R10 flags load alone", cpsr, 32'h9000_00D3);
  endtask

  initial begin
    testReset();
    testLanes();
    testBanks();
    testNoSaved();
    testUser();
    testAlu();
    testFlagLoad();
    testPriority();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule